// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch

This block produces the next micro-address for a microprogrammed controller. It keeps a 4-bit micro-program counter. The counter is the control-memory address and holds the current control state, numbered 0 to 11. On each clock edge a 2-bit address-control code picks where the counter goes next:

- back to state 0;
- to an entry of the first opcode dispatch table;
- to an entry of the second opcode dispatch table;
- to the current state plus one.

The 2-bit code is read from the control word at the current address.

The block also holds a small per-state table of sequencing codes, one per state. It presents the code for the current state on `seq_field`. A control memory can use that output as its address-control field, or a wider microcode store can compare against it. When `seq_field` is wired back to `addr_ctl`, the block steps through the full instruction flow for each supported opcode on its own. The datapath control bits are not part of this block.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 without waiting for a clock edge. After `rst_n` rises, `upc` stays 0 for at least two more rising edges while the release is synchronized.
- R2: `addr_ctl` = 0 makes `upc` 0 after the next rising edge, whatever the opcode.
- R3: `addr_ctl` = 1 loads the first dispatch table entry for the opcode. Opcode 000000 (register-register) gives 6, 000010 (jump) gives 9, 000100 (branch-equal) gives 8, 001011 (or-immediate) gives 10, and 100011 (load) and 101011 (store) both give 2.
- R4: `addr_ctl` = 2 loads the second dispatch table entry for the opcode. Load (100011) gives 3 and store (101011) gives 5.
- R5: An opcode that the selected dispatch table does not list gives state 0. This applies to both tables.
- R6: `addr_ctl` = 3 loads `upc` + 1 modulo 16, so state 15 goes to 0.
- R7: `seq_field` shows the sequencing code of the current state. States 0 to 11 give 3,1,2,3,0,0,3,0,0,0,3,0 in state order, and states 12 to 15 give 0.
- R8: With `seq_field` fed back to `addr_ctl`, each opcode runs its full state path and then returns to 0:
  - load: 0,1,2,3,4,0
  - store: 0,1,2,5,0
  - register-register: 0,1,6,7,0
  - branch-equal: 0,1,8,0
  - jump: 0,1,9,0
  - or-immediate: 0,1,10,11,0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction being interpreted |
| addr_ctl | input | 2 | Next-address select code from the current control word |
| upc | output | 4 | Micro-program counter, used as the control-memory address |
| seq_field | output | 2 | Sequencing code stored for the current state |

## Verification
A dispatch and a change of opcode can fall on the same clock edge. The register must take the dispatch entry of the opcode present at that edge, not the entry of the opcode from the previous cycle. The bench changes the opcode in every cycle of a random run, including cycles that select a dispatch. It compares `upc` after each edge against a model fed with the freshly driven opcode. A second overlap is an increment from state 15 in the same cycle as a valid dispatch opcode. It is provoked directly, and the bench expects the wrap to 0 with no influence from the tables.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ST_W  = 4;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  typedef logic [ST_W-1:0] state_t;
  typedef logic [OP_W-1:0] op_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZERO  = 2'd0,
    SEL_DISP1 = 2'd1,
    SEL_DISP2 = 2'd2,
    SEL_INC   = 2'd3
  } sel_t;

  localparam op_t OP_RR  = 6'b000000;
  localparam op_t OP_JMP = 6'b000010;
  localparam op_t OP_BEQ = 6'b000100;
  localparam op_t OP_ORI = 6'b001011;
  localparam op_t OP_LD  = 6'b100011;
  localparam op_t OP_ST  = 6'b101011;
endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int TABLE_ID = 1
) (
  input  op_t    op_i,
  output state_t tgt_o
);
  generate
    if (TABLE_ID == 1) begin : g_first
      always_comb begin
        case (op_i)
          OP_RR:   tgt_o = state_t'(6);
          OP_JMP:  tgt_o = state_t'(9);
          OP_BEQ:  tgt_o = state_t'(8);
          OP_ORI:  tgt_o = state_t'(10);
          OP_LD:   tgt_o = state_t'(2);
          OP_ST:   tgt_o = state_t'(2);
          default: tgt_o = '0;
        endcase
      end
    end else begin : g_second
      always_comb begin
        case (op_i)
          OP_LD:   tgt_o = state_t'(3);
          OP_ST:   tgt_o = state_t'(5);
          default: tgt_o = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_field_rom.sv
module useq_field_rom
  import useq_pkg::*;
(
  input  state_t           st_i,
  output logic [SEL_W-1:0] fld_o
);
  always_comb begin
    case (st_i)
      state_t'(0):  fld_o = SEL_INC;
      state_t'(1):  fld_o = SEL_DISP1;
      state_t'(2):  fld_o = SEL_DISP2;
      state_t'(3):  fld_o = SEL_INC;
      state_t'(6):  fld_o = SEL_INC;
      state_t'(10): fld_o = SEL_INC;
      default:      fld_o = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
(
  input  state_t cur_i,
  input  sel_t   sel_i,
  input  state_t d1_i,
  input  state_t d2_i,
  output state_t nxt_o
);
  state_t inc;

  always_comb inc = cur_i + state_t'(1);

  always_comb begin
    unique case (sel_i)
      SEL_ZERO:  nxt_o = '0;
      SEL_DISP1: nxt_o = d1_i;
      SEL_DISP2: nxt_o = d2_i;
      SEL_INC:   nxt_o = inc;
      default:   nxt_o = '0;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  input  logic [SEL_W-1:0] addr_ctl,
  output logic [ST_W-1:0]  upc,
  output logic [SEL_W-1:0] seq_field
);
  logic   rst_meta, rst_q;
  state_t upc_q, upc_d;
  state_t d1_tgt, d2_tgt;
  logic   upc_en;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  useq_dispatch #(.TABLE_ID(1)) i_disp1 (.op_i(opcode), .tgt_o(d1_tgt));
  useq_dispatch #(.TABLE_ID(2)) i_disp2 (.op_i(opcode), .tgt_o(d2_tgt));

  useq_addr_mux i_mux (
    .cur_i (upc_q),
    .sel_i (sel_t'(addr_ctl)),
    .d1_i  (d1_tgt),
    .d2_i  (d2_tgt),
    .nxt_o (upc_d)
  );

  useq_field_rom i_rom (.st_i(upc_q), .fld_o(seq_field));

  always_comb upc_en = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc_q <= '0;
    else if (upc_en) upc_q <= upc_d;
  end

  assign upc = upc_q;

  // assertions
  always @(posedge clk) begin
    if (!rst_n) p_reset_clear_r1: assert (upc == '0);
  end

  p_zero_sel_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_ctl == 2'd0) |=> (upc == '0));

  p_disp1_range_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_ctl == 2'd1) |=> (upc inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9, 4'd10}));

  p_disp2_range_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_ctl == 2'd2) |=> (upc inside {4'd0, 4'd3, 4'd5}));

  p_disp2_unlisted_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_ctl == 2'd2 && opcode != OP_LD && opcode != OP_ST) |=> (upc == '0));

  p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_ctl == 2'd3) |=> (upc == state_t'($past(upc) + 4'd1)));

  p_field_spare_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (upc >= 4'd12) |-> (seq_field == 2'd0));
endmodule

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [1:0] addr_ctl;
  logic [3:0] upc;
  logic [1:0] seq_field;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_st;

  always #4 clk = ~clk;

  useq_next_addr i_useq_next_addr (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .addr_ctl(addr_ctl),
    .upc(upc), .seq_field(seq_field)
  );

  function automatic logic [3:0] m_d1(input logic [5:0] op);
    case (op)
      6'b000000: return 4'd6;
      6'b000010: return 4'd9;
      6'b000100: return 4'd8;
      6'b001011: return 4'd10;
      6'b100011: return 4'd2;
      6'b101011: return 4'd2;
      default:   return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] m_d2(input logic [5:0] op);
    if (op == 6'b100011) return 4'd3;
    if (op == 6'b101011) return 4'd5;
    return 4'd0;
  endfunction

  function automatic logic [1:0] m_fld(input logic [3:0] s);
    logic [1:0] t [12] = '{2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0,
                           2'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0};
    if (s < 4'd12) return t[s];
    return 2'd0;
  endfunction

  function automatic logic [3:0] m_next(input logic [3:0] s, input logic [1:0] c,
                                        input logic [5:0] op);
    case (c)
      2'd0:    return 4'd0;
      2'd1:    return m_d1(op);
      2'd2:    return m_d2(op);
      default: return s + 4'd1;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, check after the next rising edge
  task automatic step(input logic [1:0] c, input logic [5:0] op, input string req);
    addr_ctl = c;
    opcode   = op;
    exp_st   = m_next(exp_st, c, op);
    @(negedge clk);
    check(req, upc, exp_st);
    check("R7", {2'b00, seq_field}, {2'b00, m_fld(exp_st)});
  endtask

  function automatic string sel_req(input logic [1:0] c, input logic [5:0] op);
    if (c == 2'd0) return "R2";
    if (c == 2'd3) return "R6";
    if (c == 2'd1) return (m_d1(op) == 4'd0) ? "R5" : "R3";
    return (m_d2(op) == 4'd0) ? "R5" : "R4";
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ops [6] = '{6'b100011, 6'b101011, 6'b000000,
                            6'b000100, 6'b000010, 6'b001011};
    void'($urandom(32'd7331));
    rst_n = 1'b0; addr_ctl = 2'd3; opcode = 6'b100011; exp_st = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", upc, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", upc, 4'd0);
    @(negedge clk);
    check("R1", upc, 4'd0);
    addr_ctl = 2'd0;
    @(negedge clk);

    // R8: closed-loop walk per opcode
    foreach (ops[i]) begin
      for (int n = 0; n < 8; n++) begin
        step(m_fld(exp_st), ops[i], "R8");
        if (exp_st == 4'd0) break;
      end
      check("R8", upc, 4'd0);
    end

    // R3/R4/R5 directed: dispatch from state 1 and 2 paths
    step(2'd1, 6'b111111, "R5");
    step(2'd2, 6'b000000, "R5");
    step(2'd3, 6'b000000, "R6");
    step(2'd2, 6'b101011, "R4");

    // R6: walk to 15, wrap while a dispatchable opcode is present
    step(2'd1, 6'b001011, "R3");
    for (int n = 0; n < 5; n++) step(2'd3, 6'b100011, "R6");
    check("R6", upc, 4'd15);
    step(2'd3, 6'b100011, "R6");
    check("R6", upc, 4'd0);

    // random run with opcode changes on dispatch cycles
    for (int n = 0; n < 600; n++) begin
      logic [1:0] c;
      logic [5:0] op;
      c  = 2'($urandom);
      op = ($urandom % 8 < 6) ? ops[$urandom % 6] : 6'($urandom);
      step(c, op, sel_req(c, op));
    end

    // R1: asynchronous clear mid-run
    step(2'd1, 6'b000010, "R3");
    #1 rst_n = 1'b0;
    #1 check("R1", upc, 4'd0);
    exp_st = 4'd0;
    addr_ctl = 2'd3;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", upc, 4'd0);
    @(negedge clk);
    check("R1", upc, 4'd0);
    addr_ctl = 2'd0;
    @(negedge clk);
    step(2'd3, 6'b000000, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule